// File: doc/BRIEF.md
# Banked Memory-Ordering Queue with Per-Bank Hash Filters

This block tracks in-flight loads and stores in program order and checks memory ordering when each one executes. The queue is split into banks. An entry's age tag sets its bank: the bank is the tag modulo the bank count, so consecutive allocations go to the banks in turn. Each bank has a small table of counters indexed by a hash of the address. When an operation executes, every bank's table is read at the same hashed location in parallel. A nonzero counter marks the bank as a possible match. Only marked banks run their associative compare, and the other banks stay idle. If no bank is marked, no entry is compared at all.

For an executing load, the merged result names the youngest older store that has executed with the same address, so its data can be forwarded. For an executing store, it names the oldest younger load that has already executed with the same address, which is an ordering violation. The executing entry then increments the counter in its own bank. Retiring or squashing an executed entry decrements that counter. The per-cycle bank-enable vector is an output, so the saving over a full search can be measured.

Allocation happens at the tail. Retirement happens at the head. Squash removes the youngest entry, one per cycle. Age comparisons are taken relative to the head, so tags may wrap freely.

Top module: `lsq_banked_filter`

## Requirements
- R1: After reset the queue is empty: `empty`=1 and `full`=0. No result is valid, and every filter counter is zero.
- R2: `alloc_tag` shows the tag the next allocation receives. Tags start at 0 and count up modulo 32. A new entry lives in bank (tag mod 4).
- R3: One cycle after `exec_valid`, `res_valid`=1 and `res_bank_en` bit b is set exactly when bank b holds an executed, still-live entry whose address hash equals that of `exec_addr`. The hash is the XOR of the four 4-bit nibbles of the 16-bit address.
- R4: If no bank reports a possible match, `res_bank_en` is 0 and both hit flags are 0. Without `exec_valid`, all result outputs are 0.
- R5: For an executing load, `fwd_hit`/`fwd_tag` name the youngest executed store with an equal address that is older than the load, chosen across all banks.
- R6: For an executing store, `viol_hit`/`viol_tag` name the oldest executed load with an equal address that is younger than the store, chosen across all banks.
- R7: Execution increments its own bank's counter at the hashed location. Retiring or squashing an executed entry decrements it, so a bank whose only matching entries have left no longer reports a match.
- R8: The queue holds 32 entries. `full` is set at 32. An allocation while full is ignored and leaves `alloc_tag` unchanged.
- R9: Age order is measured from the head, so forwarding and violation choices stay correct after tags wrap past 31.
- R10: A hash alias with an unequal address enables the bank but yields no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a new entry at the tail |
| alloc_store | input | 1 | New entry is a store (1) or a load (0) |
| alloc_tag | output | 5 | Tag the next allocation receives |
| full | output | 1 | All 32 entries in use |
| empty | output | 1 | No entry in use |
| exec_valid | input | 1 | An allocated entry executes this cycle |
| exec_tag | input | 5 | Tag of the executing entry |
| exec_addr | input | 16 | Address of the executing entry |
| retire_valid | input | 1 | Remove the oldest entry |
| squash_valid | input | 1 | Remove the youngest entry |
| res_valid | output | 1 | Result of last cycle's execution |
| res_bank_en | output | 4 | Banks whose associative search ran |
| fwd_hit | output | 1 | Forwarding store found for a load |
| fwd_tag | output | 5 | Tag of the forwarding store |
| viol_hit | output | 1 | Violating load found for a store |
| viol_tag | output | 5 | Tag of the violating load |

## Verification
The bench uses the default parameters: four banks of eight rows, 16-bit addresses and 4-bit hashes. With only 32 entries, a fill to capacity and many tag wraps fit in a short run. With only 16 hash slots, aliases such as 0x0012 and 0x0300 are easy to build, so enabled banks that produce no hit can be exercised on purpose. A directed sequence places matching stores and loads in different banks to test the cross-bank merge. A pseudo-random phase then mixes allocation, execution, retirement and squash against a reference model.

// File: rtl/lsq_bf_pkg.sv
package lsq_bf_pkg;
    typedef enum logic {
        KIND_LOAD  = 1'b0,
        KIND_STORE = 1'b1
    } mem_kind_e;
endpackage

// File: rtl/lsq_bf_filter.sv
module lsq_bf_filter #(
    parameter int HASH_W = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HASH_W-1:0] look_idx,
    output logic              look_hit,
    input  logic              inc_en,
    input  logic [HASH_W-1:0] inc_idx,
    input  logic              dec0_en,
    input  logic [HASH_W-1:0] dec0_idx,
    input  logic              dec1_en,
    input  logic [HASH_W-1:0] dec1_idx
);
    localparam int SLOTS = 1 << HASH_W;

    typedef logic [CNT_W-1:0] cnt_t;

    cnt_t cnt_d [SLOTS];
    cnt_t cnt_q [SLOTS];

    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            cnt_d[s] = cnt_q[s];
            if (inc_en && inc_idx == HASH_W'(s))
                cnt_d[s] = cnt_d[s] + cnt_t'(1);
            if (dec0_en && dec0_idx == HASH_W'(s))
                cnt_d[s] = cnt_d[s] - cnt_t'(1);
            if (dec1_en && dec1_idx == HASH_W'(s))
                cnt_d[s] = cnt_d[s] - cnt_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) cnt_q[s] <= '0;
        end else begin
            for (int s = 0; s < SLOTS; s++) cnt_q[s] <= cnt_d[s];
        end
    end

    assign look_hit = (cnt_q[look_idx] != '0);
endmodule

// File: rtl/lsq_bf_bank_search.sv
module lsq_bf_bank_search #(
    parameter int ROWS   = 8,
    parameter int IDX_W  = 5,
    parameter int ADDR_W = 16
) (
    input  logic                        search_en,
    input  logic                        want_store,
    input  logic                        want_older,
    input  logic [ADDR_W-1:0]           key_addr,
    input  logic [IDX_W-1:0]            key_rel,
    input  logic [ROWS-1:0]             row_live,
    input  logic [ROWS-1:0]             row_store,
    input  logic [ROWS-1:0][ADDR_W-1:0] row_addr,
    input  logic [ROWS-1:0][IDX_W-1:0]  row_rel,
    output logic                        hit,
    output logic [IDX_W-1:0]            best_rel
);
    always_comb begin
        hit      = 1'b0;
        best_rel = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (search_en && row_live[r] && (row_store[r] == want_store) &&
                (row_addr[r] == key_addr) &&
                (want_older ? (row_rel[r] < key_rel) : (row_rel[r] > key_rel))) begin
                if (!hit || (want_older ? (row_rel[r] > best_rel)
                                        : (row_rel[r] < best_rel))) begin
                    hit      = 1'b1;
                    best_rel = row_rel[r];
                end
            end
        end
    end
endmodule

// File: rtl/lsq_banked_filter.sv
module lsq_banked_filter
    import lsq_bf_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_ROWS = 8,
    parameter int ADDR_W    = 16,
    parameter int HASH_W    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_valid,
    input  logic                         alloc_store,
    output logic [$clog2(NUM_BANKS*BANK_ROWS)-1:0] alloc_tag,
    output logic                         full,
    output logic                         empty,
    input  logic                         exec_valid,
    input  logic [$clog2(NUM_BANKS*BANK_ROWS)-1:0] exec_tag,
    input  logic [ADDR_W-1:0]            exec_addr,
    input  logic                         retire_valid,
    input  logic                         squash_valid,
    output logic                         res_valid,
    output logic [NUM_BANKS-1:0]         res_bank_en,
    output logic                         fwd_hit,
    output logic [$clog2(NUM_BANKS*BANK_ROWS)-1:0] fwd_tag,
    output logic                         viol_hit,
    output logic [$clog2(NUM_BANKS*BANK_ROWS)-1:0] viol_tag
);
    localparam int TOTAL  = NUM_BANKS * BANK_ROWS;
    localparam int IDX_W  = $clog2(TOTAL);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int CNT_W  = $clog2(BANK_ROWS) + 1;
    localparam int NCHUNK = (ADDR_W + HASH_W - 1) / HASH_W;

    typedef logic [IDX_W-1:0] tag_t;

    typedef struct packed {
        logic              valid;
        logic              done;
        mem_kind_e         kind;
        logic [ADDR_W-1:0] addr;
    } entry_t;

    typedef struct packed {
        entry_t [TOTAL-1:0]   ent;
        tag_t                 head;
        tag_t                 tail;
        logic [IDX_W:0]       count;
        logic                 res_valid;
        logic [NUM_BANKS-1:0] res_en;
        logic                 fwd_hit;
        tag_t                 fwd_tag;
        logic                 viol_hit;
        tag_t                 viol_tag;
    } state_t;

    function automatic logic [HASH_W-1:0] fold_hash(input logic [ADDR_W-1:0] a);
        logic [NCHUNK*HASH_W-1:0] ext;
        logic [HASH_W-1:0]        h;
        ext = (NCHUNK*HASH_W)'(a);
        h   = '0;
        for (int c = 0; c < NCHUNK; c++) h = h ^ ext[c*HASH_W +: HASH_W];
        return h;
    endfunction

    state_t st_d, st_q;

    logic [HASH_W-1:0]    exec_hash;
    mem_kind_e            exec_kind;
    tag_t                 exec_rel;
    entry_t               head_ent;
    entry_t               last_ent;
    tag_t                 last_tag;
    logic                 do_retire;
    logic                 do_squash;
    logic                 do_alloc;
    logic [NUM_BANKS-1:0] filt_hit;
    logic [NUM_BANKS-1:0] bank_en;
    logic [NUM_BANKS-1:0] bank_hit;
    tag_t                 bank_rel [NUM_BANKS];
    logic                 m_hit;
    tag_t                 m_rel;

    assign exec_hash = fold_hash(exec_addr);
    assign exec_kind = st_q.ent[exec_tag].kind;
    assign exec_rel  = exec_tag - st_q.head;
    assign head_ent  = st_q.ent[st_q.head];
    assign last_tag  = st_q.tail - tag_t'(1);
    assign last_ent  = st_q.ent[last_tag];
    assign do_retire = retire_valid && (st_q.count != '0);
    assign do_squash = squash_valid && (st_q.count != '0);
    assign do_alloc  = alloc_valid && !do_squash && (st_q.count != (IDX_W+1)'(TOTAL));
    assign bank_en   = exec_valid ? filt_hit : '0;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_ROWS-1:0]             live;
        logic [BANK_ROWS-1:0]             is_st;
        logic [BANK_ROWS-1:0][ADDR_W-1:0] raddr;
        logic [BANK_ROWS-1:0][IDX_W-1:0]  rrel;

        always_comb begin
            for (int r = 0; r < BANK_ROWS; r++) begin
                live[r]  = st_q.ent[r*NUM_BANKS + b].valid && st_q.ent[r*NUM_BANKS + b].done;
                is_st[r] = (st_q.ent[r*NUM_BANKS + b].kind == KIND_STORE);
                raddr[r] = st_q.ent[r*NUM_BANKS + b].addr;
                rrel[r]  = tag_t'(r*NUM_BANKS + b) - st_q.head;
            end
        end

        lsq_bf_filter #(
            .HASH_W(HASH_W),
            .CNT_W (CNT_W)
        ) u_filter (
            .clk     (clk),
            .rst_n   (rst_n),
            .look_idx(exec_hash),
            .look_hit(filt_hit[b]),
            .inc_en  (exec_valid && (exec_tag[BANK_W-1:0] == BANK_W'(b))),
            .inc_idx (exec_hash),
            .dec0_en (do_retire && head_ent.done && (st_q.head[BANK_W-1:0] == BANK_W'(b))),
            .dec0_idx(fold_hash(head_ent.addr)),
            .dec1_en (do_squash && last_ent.done && (last_tag[BANK_W-1:0] == BANK_W'(b))),
            .dec1_idx(fold_hash(last_ent.addr))
        );

        lsq_bf_bank_search #(
            .ROWS  (BANK_ROWS),
            .IDX_W (IDX_W),
            .ADDR_W(ADDR_W)
        ) u_search (
            .search_en (bank_en[b]),
            .want_store(exec_kind == KIND_LOAD),
            .want_older(exec_kind == KIND_LOAD),
            .key_addr  (exec_addr),
            .key_rel   (exec_rel),
            .row_live  (live),
            .row_store (is_st),
            .row_addr  (raddr),
            .row_rel   (rrel),
            .hit       (bank_hit[b]),
            .best_rel  (bank_rel[b])
        );
    end

    always_comb begin
        m_hit = 1'b0;
        m_rel = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b] && (!m_hit ||
                ((exec_kind == KIND_LOAD) ? (bank_rel[b] > m_rel) : (bank_rel[b] < m_rel)))) begin
                m_hit = 1'b1;
                m_rel = bank_rel[b];
            end
        end
    end

    always_comb begin
        st_d = st_q;

        st_d.res_valid = exec_valid;
        st_d.res_en    = bank_en;
        st_d.fwd_hit   = exec_valid && (exec_kind == KIND_LOAD) && m_hit;
        st_d.fwd_tag   = st_d.fwd_hit ? (m_rel + st_q.head) : '0;
        st_d.viol_hit  = exec_valid && (exec_kind == KIND_STORE) && m_hit;
        st_d.viol_tag  = st_d.viol_hit ? (m_rel + st_q.head) : '0;

        if (exec_valid) begin
            st_d.ent[exec_tag].done = 1'b1;
            st_d.ent[exec_tag].addr = exec_addr;
        end
        if (do_retire) begin
            st_d.ent[st_q.head].valid = 1'b0;
            st_d.head = st_q.head + tag_t'(1);
        end
        if (do_squash) begin
            st_d.ent[last_tag].valid = 1'b0;
            st_d.tail = last_tag;
        end
        if (do_alloc) begin
            st_d.ent[st_q.tail].valid = 1'b1;
            st_d.ent[st_q.tail].done  = 1'b0;
            st_d.ent[st_q.tail].kind  = alloc_store ? KIND_STORE : KIND_LOAD;
            st_d.ent[st_q.tail].addr  = '0;
            st_d.tail = st_q.tail + tag_t'(1);
        end
        st_d.count = st_q.count + (IDX_W+1)'(do_alloc)
                   - (IDX_W+1)'(do_retire) - (IDX_W+1)'(do_squash);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alloc_tag   = st_q.tail;
    assign full        = (st_q.count == (IDX_W+1)'(TOTAL));
    assign empty       = (st_q.count == '0);
    assign res_valid   = st_q.res_valid;
    assign res_bank_en = st_q.res_en;
    assign fwd_hit     = st_q.fwd_hit;
    assign fwd_tag     = st_q.fwd_tag;
    assign viol_hit    = st_q.viol_hit;
    assign viol_tag    = st_q.viol_tag;
endmodule

// File: rtl/lsq_banked_filter_chk.sv
module lsq_banked_filter_chk #(
    parameter int NUM_BANKS = 4,
    parameter int IDX_W     = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 alloc_valid,
    input logic [IDX_W-1:0]     alloc_tag,
    input logic                 full,
    input logic                 empty,
    input logic                 exec_valid,
    input logic                 retire_valid,
    input logic                 squash_valid,
    input logic                 res_valid,
    input logic [NUM_BANKS-1:0] res_bank_en,
    input logic                 fwd_hit,
    input logic [IDX_W-1:0]     fwd_tag,
    input logic                 viol_hit,
    input logic [IDX_W-1:0]     viol_tag
);
    localparam int BANK_W = $clog2(NUM_BANKS);

    a_r1_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (empty && !full && !res_valid));

    a_r2_tag_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !full && !squash_valid) |=> (alloc_tag == $past(alloc_tag) + 1'b1));

    a_r3_result_follows_exec: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(exec_valid));

    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_bank_en == '0 && !fwd_hit && !viol_hit));

    a_r5_fwd_from_enabled_bank: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hit |-> res_bank_en[fwd_tag[BANK_W-1:0]]);

    a_r6_viol_from_enabled_bank: assert property (@(posedge clk) disable iff (!rst_n)
        viol_hit |-> res_bank_en[viol_tag[BANK_W-1:0]]);

    a_r6_single_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_hit && viol_hit));

    a_r8_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && alloc_valid && !retire_valid && !squash_valid) |=> (full && $stable(alloc_tag)));
endmodule

bind lsq_banked_filter lsq_banked_filter_chk #(
    .NUM_BANKS(NUM_BANKS),
    .IDX_W    (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .alloc_tag   (alloc_tag),
    .full        (full),
    .empty       (empty),
    .exec_valid  (exec_valid),
    .retire_valid(retire_valid),
    .squash_valid(squash_valid),
    .res_valid   (res_valid),
    .res_bank_en (res_bank_en),
    .fwd_hit     (fwd_hit),
    .fwd_tag     (fwd_tag),
    .viol_hit    (viol_hit),
    .viol_tag    (viol_tag)
);

// File: tb/lsq_banked_filter_test.sv
module lsq_banked_filter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic        alloc_store = 1'b0;
    logic [4:0]  alloc_tag;
    logic        full, empty;
    logic        exec_valid = 1'b0;
    logic [4:0]  exec_tag = '0;
    logic [15:0] exec_addr = '0;
    logic        retire_valid = 1'b0;
    logic        squash_valid = 1'b0;
    logic        res_valid;
    logic [3:0]  res_bank_en;
    logic        fwd_hit, viol_hit;
    logic [4:0]  fwd_tag, viol_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsq_banked_filter uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_store(alloc_store), .alloc_tag(alloc_tag),
        .full(full), .empty(empty),
        .exec_valid(exec_valid), .exec_tag(exec_tag), .exec_addr(exec_addr),
        .retire_valid(retire_valid), .squash_valid(squash_valid),
        .res_valid(res_valid), .res_bank_en(res_bank_en),
        .fwd_hit(fwd_hit), .fwd_tag(fwd_tag),
        .viol_hit(viol_hit), .viol_tag(viol_tag)
    );

    typedef struct {
        logic [3:0] en;
        bit         fh;
        logic [4:0] ft;
        bit         vh;
        logic [4:0] vt;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    int   searched_banks = 0;
    int   full_banks = 0;

    bit          m_valid [32];
    bit          m_done  [32];
    bit          m_store [32];
    logic [15:0] m_addr  [32];
    int          m_head = 0;
    int          m_tail = 0;
    int          m_count = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [3:0] hf(input logic [15:0] a);
        return a[3:0] ^ a[7:4] ^ a[11:8] ^ a[15:12];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        alloc_valid = 1'b0; alloc_store = 1'b0; exec_valid = 1'b0;
        retire_valid = 1'b0; squash_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic chk_flags(input string req);
        check(empty == (m_count == 0), req, "empty", int'(empty), int'(m_count == 0));
        check(full == (m_count == 32), req, "full", int'(full), int'(m_count == 32));
    endtask

    task automatic do_alloc(input bit st, input string req);
        @(negedge clk);
        clear_inputs();
        check(alloc_tag == 5'(m_tail), req, "alloc_tag", int'(alloc_tag), m_tail);
        alloc_valid = 1'b1;
        alloc_store = st;
        if (m_count < 32) begin
            m_valid[m_tail] = 1'b1;
            m_done[m_tail]  = 1'b0;
            m_store[m_tail] = st;
            m_tail  = (m_tail + 1) % 32;
            m_count++;
        end
    endtask

    task automatic do_exec(input int tag, input logic [15:0] a, input string req);
        exp_t e;
        int   rt, ri, fr, vr;
        @(negedge clk);
        clear_inputs();
        e.en = '0; e.fh = 0; e.ft = '0; e.vh = 0; e.vt = '0; e.req = req;
        fr = 0; vr = 0;
        rt = (tag - m_head + 32) % 32;
        for (int i = 0; i < 32; i++) begin
            if (m_valid[i] && m_done[i]) begin
                if (hf(m_addr[i]) == hf(a)) e.en[i % 4] = 1'b1;
                ri = (i - m_head + 32) % 32;
                if (m_addr[i] == a) begin
                    if (!m_store[tag] && m_store[i] && ri < rt && (!e.fh || ri > fr)) begin
                        e.fh = 1; fr = ri;
                    end
                    if (m_store[tag] && !m_store[i] && ri > rt && (!e.vh || ri < vr)) begin
                        e.vh = 1; vr = ri;
                    end
                end
            end
        end
        if (e.fh) e.ft = 5'((fr + m_head) % 32);
        if (e.vh) e.vt = 5'((vr + m_head) % 32);
        exp_q.push_back(e);
        exec_valid = 1'b1;
        exec_tag   = 5'(tag);
        exec_addr  = a;
        m_done[tag] = 1'b1;
        m_addr[tag] = a;
    endtask

    task automatic do_retire();
        @(negedge clk);
        clear_inputs();
        retire_valid = 1'b1;
        if (m_count > 0) begin
            m_valid[m_head] = 1'b0;
            m_head = (m_head + 1) % 32;
            m_count--;
        end
    endtask

    task automatic do_squash();
        @(negedge clk);
        clear_inputs();
        squash_valid = 1'b1;
        if (m_count > 0) begin
            m_tail = (m_tail + 31) % 32;
            m_valid[m_tail] = 1'b0;
            m_count--;
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3", "unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                searched_banks += $countones(res_bank_en);
                full_banks     += 4;
                check(res_bank_en == e.en, {e.req, "/R3"}, "bank_en", int'(res_bank_en), int'(e.en));
                check(fwd_hit == e.fh && (!e.fh || fwd_tag == e.ft), {e.req, "/R5"}, "fwd",
                      int'({fwd_hit, fwd_tag}), int'({e.fh, e.ft}));
                check(viol_hit == e.vh && (!e.vh || viol_tag == e.vt), {e.req, "/R6"}, "viol",
                      int'({viol_hit, viol_tag}), int'({e.vh, e.vt}));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_valid[i] = 0; m_done[i] = 0; m_store[i] = 0; m_addr[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_flags("R1");
        check(res_valid == 1'b0, "R1", "res_valid", int'(res_valid), 0);

        // Entries 0..7: S L S L S L L S, banks 0 1 2 3 0 1 2 3
        do_alloc(1, "R2"); do_alloc(0, "R2"); do_alloc(1, "R2"); do_alloc(0, "R2");
        do_alloc(1, "R2"); do_alloc(0, "R2"); do_alloc(0, "R2"); do_alloc(1, "R2");
        do_exec(1, 16'h0012, "R4");   // nothing executed: no bank searched
        do_exec(0, 16'h0012, "R6");   // younger load 1 already executed
        do_exec(2, 16'h0012, "R6");   // only older load: banks enabled, no violation
        do_exec(5, 16'h0012, "R5");   // youngest older store is 2
        do_exec(4, 16'h0012, "R6");   // younger load 5 violates
        do_exec(3, 16'h0300, "R10");  // alias of hash 3, unequal address
        do_exec(6, 16'h0012, "R5");   // store 4 in bank 0 beats store 2 in bank 2
        idle();
        repeat (4) do_retire();
        do_squash();                  // store 7, not executed
        do_squash();                  // load 6, executed: bank 2 counter drops
        do_alloc(1, "R7");
        do_exec(6, 16'h0012, "R7");   // bank 2 no longer reports a match
        idle();
        while (m_count > 0) do_retire();
        idle();
        chk_flags("R8");

        for (int k = 0; k < 32; k++) do_alloc(k[0], "R8");
        idle();
        chk_flags("R8");
        do_alloc(1, "R8");            // ignored, tag must not move
        idle();
        chk_flags("R8");
        check(alloc_tag == 5'(m_tail), "R8", "tag after refused alloc", int'(alloc_tag), m_tail);
        while (m_count > 0) do_retire();
        idle();
        chk_flags("R8");

        // Mixed traffic across many tag wraps (R9)
        for (int n = 0; n < 3000; n++) begin
            int op;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            op = int'(lfsr[2:0]);
            if (op <= 2 && m_count < 32) begin
                do_alloc(lfsr[5], "R9");
            end else if ((op == 3 || op == 4) && m_count > 0) begin
                int pick;
                logic [15:0] a;
                pick = -1;
                for (int j = 0; j < 32; j++) begin
                    int t;
                    t = (m_head + (int'(lfsr[10:6]) + j) % m_count) % 32;
                    if (pick < 0 && m_valid[t] && !m_done[t]) pick = t;
                end
                case (int'(lfsr[13:11]) % 5)
                    0: a = 16'h0012;
                    1: a = 16'h0300;
                    2: a = 16'h0005;
                    3: a = 16'h0012;
                    default: a = 16'h0050;
                endcase
                if (pick >= 0) do_exec(pick, a, "R9");
                else idle();
            end else if (op == 5 && m_count > 0) begin
                do_retire();
            end else if (op == 6 && m_count > 1) begin
                do_squash();
            end else begin
                idle();
            end
        end
        idle();
        idle();
        chk_flags("R9");
        check(exp_q.size() == 0, "R3", "pending results", exp_q.size(), 0);
        $display("banks searched=%0d of %0d", searched_banks, full_banks);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule